// File: doc/BRIEF.md
# Flash Query and Identification Read Responder

This block supplies read data for a parallel flash bank while the bank is in parameter-query mode or in identification mode. The bank is built from identical devices placed side by side on the data bus. Each device may be narrower than its widest native width. The surrounding controller decodes the commands and selects the mode. For each read it presents the byte offset, the access width and the static width configuration, then pulses a request strobe. One cycle later the block returns a registered 32-bit word.

Inside, each offset is scaled down to a table index according to the bank, device and maximum device widths. The index selects either a byte of the parameter table or an identifier code. The table is built at elaboration time from the sector and block-count parameters. A single-device answer is copied into every device slice of the bank. A read that is wider than the bank is assembled from several bank-wide answers.

Widths are given as log2 codes on the ports: 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes.

Top module: `fqr_responder`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req` high. `rsp_data` is loaded only on a request and holds its value otherwise.
- R2: The table index is the offset shifted right by (bank code + max-device code − device code), all codes being log2 byte widths (0 = 1 B, 1 = 2 B, 2 = 4 B).
- R3: In query mode the table returns these values. Indices 0x10..0x14 hold 0x51, 0x52, 0x59, 0x01, 0x00. Index 0x27 holds log2 of one device's size in bytes. Index 0x2A holds 0x08 for a 1-byte bank and 0x0B otherwise. Index 0x2C holds 0x01. Indices 0x2D/0x2E hold the low and high bytes of (blocks per device − 1). Indices 0x2F/0x30 hold the sector length shifted right by 8 and by 16. Index 0x3F holds 0x01.
- R4: In query mode an index above 0x52 returns zero.
- R5: In query mode, when the device width differs from the max device width, the following applies. Device width 1 repeats the table byte in every byte. Any other device width returns zero.
- R6: Each single-device answer, taken as its low device-width slice, is copied into every device slice of the bank width.
- R7: In identification mode only index bits [7:0] are decoded: 0 gives `MANUF_ID`, 1 gives `DEVICE_ID`, and any other value gives zero.
- R8: When the access is wider than the bank, byte lane p (a multiple of the bank width) takes the bank-wide answer for offset + p × bank width.
- R9: Bytes at or above the access width read zero. An access narrower than the bank returns the low bytes of the bank answer.
- R10: During reset `rsp_valid` and `rsp_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request strobe |
| mode_id | input | 1 | 1 = identification mode, 0 = query mode |
| offset | input | ADDR_W | Byte offset of the read |
| acc_lg | input | 2 | log2 of access width in bytes |
| bank_lg | input | 2 | log2 of bank width in bytes |
| dev_lg | input | 2 | log2 of device width in bytes |
| max_lg | input | 2 | log2 of maximum device width in bytes |
| rsp_valid | output | 1 | Response valid, one cycle after `req` |
| rsp_data | output | 32 | Response data |

## Verification
Some rules are checked on every clock. These are the request-to-valid timing and the holding of data between requests. They also cover the zero answer for query indices beyond the table and for undecoded identifier indices, the byte repetition of a single-byte device inside a wider part, and zero bytes above a one-byte access. Other behaviour shows only through the bench's chosen reads. This includes the actual table contents and their dependence on bank and device widths, the index scaling across width combinations, the placement of chunks in multi-chunk reads, and the behaviour around reset.

// File: rtl/fqr_pkg.sv
package fqr_pkg;

    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = 8 * BUS_BYTES;

    // highest defined query index; everything beyond reads zero
    localparam logic [7:0] TABLE_LAST = 8'h52;

    // log2 width codes
    localparam logic [1:0] WC_1B = 2'd0;
    localparam logic [1:0] WC_2B = 2'd1;
    localparam logic [1:0] WC_4B = 2'd2;

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] data;
    } rsp_t;

endpackage

// File: rtl/fqr_index.sv
module fqr_index #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        max_lg,
    output logic [ADDR_W-1:0] idx
);

    logic [2:0] span;
    logic [2:0] shamt;

    always_comb begin
        span  = {1'b0, bank_lg} + {1'b0, max_lg};
        shamt = (span >= {1'b0, dev_lg}) ? (span - {1'b0, dev_lg}) : 3'd0;
        idx   = offset >> shamt;
    end

endmodule

// File: rtl/fqr_param_rom.sv
module fqr_param_rom
    import fqr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SECTOR_LOG2 = 16,
    parameter int BLOCKS_LOG2 = 7
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    output logic [7:0]        tbl_byte
);

    localparam logic [31:0] SECTOR_LEN = 32'd1 << SECTOR_LOG2;
    localparam logic [7:0]  SEC_MID    = SECTOR_LEN[15:8];
    localparam logic [7:0]  SEC_HIGH   = SECTOR_LEN[23:16];

    logic [1:0]  ndev_lg;
    logic [7:0]  bpd_lg;
    logic [15:0] bpd_m1;
    logic [7:0]  size_lg;
    logic        in_range;

    always_comb begin
        ndev_lg  = (bank_lg > dev_lg) ? (bank_lg - dev_lg) : 2'd0;
        bpd_lg   = 8'(BLOCKS_LOG2) - {6'd0, ndev_lg};
        bpd_m1   = 16'((32'd1 << bpd_lg) - 32'd1);
        size_lg  = 8'(SECTOR_LOG2) + bpd_lg;
        in_range = (idx <= ADDR_W'(TABLE_LAST));
        tbl_byte = 8'h00;
        if (in_range) begin
            case (idx[6:0])
                7'h10: tbl_byte = 8'h51;
                7'h11: tbl_byte = 8'h52;
                7'h12: tbl_byte = 8'h59;
                7'h13: tbl_byte = 8'h01;
                7'h15: tbl_byte = 8'h31;
                7'h1B: tbl_byte = 8'h45;
                7'h1C: tbl_byte = 8'h55;
                7'h1F: tbl_byte = 8'h07;
                7'h20: tbl_byte = 8'h07;
                7'h21: tbl_byte = 8'h0A;
                7'h23: tbl_byte = 8'h04;
                7'h24: tbl_byte = 8'h04;
                7'h25: tbl_byte = 8'h04;
                7'h27: tbl_byte = size_lg;
                7'h28: tbl_byte = 8'h02;
                7'h2A: tbl_byte = (bank_lg == WC_1B) ? 8'h08 : 8'h0B;
                7'h2C: tbl_byte = 8'h01;
                7'h2D: tbl_byte = bpd_m1[7:0];
                7'h2E: tbl_byte = bpd_m1[15:8];
                7'h2F: tbl_byte = SEC_MID;
                7'h30: tbl_byte = SEC_HIGH;
                7'h31: tbl_byte = 8'h50;
                7'h32: tbl_byte = 8'h52;
                7'h33: tbl_byte = 8'h49;
                7'h34: tbl_byte = 8'h31;
                7'h35: tbl_byte = 8'h30;
                7'h3F: tbl_byte = 8'h01;
                default: tbl_byte = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/fqr_lane.sv
module fqr_lane
    import fqr_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          SECTOR_LOG2 = 16,
    parameter int          BLOCKS_LOG2 = 7,
    parameter logic [15:0] MANUF_ID    = 16'h0089,
    parameter logic [15:0] DEVICE_ID   = 16'h0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] offset,
    input  logic              mode_id,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        max_lg,
    output logic [BUS_W-1:0]  resp
);

    logic [ADDR_W-1:0] idx;
    logic [7:0]        tbl_byte;
    logic [BUS_W-1:0]  base;
    logic [BUS_W-1:0]  rep;
    logic [BUS_W-1:0]  bank_mask;

    fqr_index #(.ADDR_W(ADDR_W)) u_index (
        .offset (offset),
        .bank_lg(bank_lg),
        .dev_lg (dev_lg),
        .max_lg (max_lg),
        .idx    (idx)
    );

    fqr_param_rom #(
        .ADDR_W     (ADDR_W),
        .SECTOR_LOG2(SECTOR_LOG2),
        .BLOCKS_LOG2(BLOCKS_LOG2)
    ) u_rom (
        .idx     (idx),
        .bank_lg (bank_lg),
        .dev_lg  (dev_lg),
        .tbl_byte(tbl_byte)
    );

    always_comb begin
        base = '0;
        if (mode_id) begin
            case (idx[7:0])
                8'h00:   base = {16'h0000, MANUF_ID};
                8'h01:   base = {16'h0000, DEVICE_ID};
                default: base = '0;
            endcase
        end else if (dev_lg != max_lg) begin
            base = (dev_lg == WC_1B) ? {BUS_BYTES{tbl_byte}} : '0;
        end else begin
            base = {24'h000000, tbl_byte};
        end

        case (dev_lg)
            WC_1B:   rep = {4{base[7:0]}};
            WC_2B:   rep = {2{base[15:0]}};
            default: rep = base;
        endcase

        case (bank_lg)
            WC_1B:   bank_mask = 32'h0000_00FF;
            WC_2B:   bank_mask = 32'h0000_FFFF;
            default: bank_mask = 32'hFFFF_FFFF;
        endcase

        resp = rep & bank_mask;
    end

    // R4: query indices past the table read zero
    a_r4_beyond_table: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_id && idx > ADDR_W'(TABLE_LAST)) |-> (resp == '0));

    // R7: undecoded identification indices read zero
    a_r7_id_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_id && idx[7:0] > 8'h01) |-> (resp == '0));

    // R5: a byte-wide device in a wider part repeats the table byte
    a_r5_x8_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_id && dev_lg == WC_1B && max_lg != WC_1B && bank_lg == WC_4B)
        |-> (resp == {4{tbl_byte}}));

endmodule

// File: rtl/fqr_responder.sv
module fqr_responder
    import fqr_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          SECTOR_LOG2 = 16,
    parameter int          BLOCKS_LOG2 = 7,
    parameter logic [15:0] MANUF_ID    = 16'h0089,
    parameter logic [15:0] DEVICE_ID   = 16'h0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              mode_id,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        acc_lg,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        max_lg,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_data
);

    logic [BUS_W-1:0] lane_resp [BUS_BYTES];
    logic [BUS_W-1:0] assembled;
    rsp_t             rsp_d, rsp_q;

    // one responder per byte position; only positions on a bank boundary are used
    for (genvar p = 0; p < BUS_BYTES; p++) begin : g_lane
        logic [ADDR_W-1:0] lane_off;
        assign lane_off = offset + (ADDR_W'(p) << bank_lg);

        fqr_lane #(
            .ADDR_W     (ADDR_W),
            .SECTOR_LOG2(SECTOR_LOG2),
            .BLOCKS_LOG2(BLOCKS_LOG2),
            .MANUF_ID   (MANUF_ID),
            .DEVICE_ID  (DEVICE_ID)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .offset (lane_off),
            .mode_id(mode_id),
            .bank_lg(bank_lg),
            .dev_lg (dev_lg),
            .max_lg (max_lg),
            .resp   (lane_resp[p])
        );
    end

    always_comb begin
        logic [1:0] bmask;
        logic [1:0] chunk;
        logic [1:0] rel;
        bmask     = 2'((3'd1 << bank_lg) - 3'd1);
        assembled = '0;
        for (int p = 0; p < BUS_BYTES; p++) begin
            chunk = 2'(p) & ~bmask;
            rel   = 2'(p) & bmask;
            if (3'(p) < (3'd1 << acc_lg)) begin
                assembled[8*p +: 8] = lane_resp[chunk][{rel, 3'b000} +: 8];
            end
        end
    end

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req;
        if (req) begin
            rsp_d.data = assembled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_data  = rsp_q.data;

    // R1: response one cycle after request, nothing otherwise
    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    a_r1_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(rsp_data));

    // R9: a one-byte access leaves the upper bytes zero
    a_r9_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && acc_lg == WC_1B) |=> (rsp_data[BUS_W-1:8] == '0));

endmodule

// File: tb/sim_fqr_responder.sv
module sim_fqr_responder;

    typedef struct packed {
        logic        mode;
        logic [1:0]  bank;
        logic [1:0]  dev;
        logic [1:0]  maxw;
        logic [1:0]  acc;
        logic [15:0] off;
        logic [31:0] exp;
        logic [7:0]  req_no;
    } vec_t;

    localparam int NV = 22;
    // codes: width 0 = 1 B, 1 = 2 B, 2 = 4 B ; ids 0x0089 / 0x0018
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h0000_0051, 8'd3},  // R3 signature
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd2, 16'h0010, 32'h0159_5251, 8'd8},  // R8 four 1-byte chunks
        '{1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0020, 32'h0000_0051, 8'd2},  // R2 x16 shift
        '{1'b0, 2'd2, 2'd1, 2'd1, 2'd2, 16'h00A8, 32'h000B_000B, 8'd6},  // R6 two x16 devices
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd2, 16'h002A, 32'h7F01_0008, 8'd3},  // R3 buf exp, region, blocks
        '{1'b0, 2'd2, 2'd0, 2'd1, 2'd2, 16'h0088, 32'h5252_5252, 8'd5},  // R5 x8 in x16 part
        '{1'b0, 2'd1, 2'd1, 2'd2, 2'd1, 16'h0040, 32'h0000_0000, 8'd5},  // R5 unsupported combo
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0053, 32'h0000_0000, 8'd4},  // R4 just past table
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0060, 32'h0000_0000, 8'd4},  // R4 far past table
        '{1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0000, 32'h0000_0089, 8'd7},  // R7 manufacturer
        '{1'b1, 2'd2, 2'd0, 2'd0, 2'd2, 16'h0004, 32'h1818_1818, 8'd7},  // R7 device, 4 x8 devices
        '{1'b1, 2'd0, 2'd0, 2'd0, 2'd2, 16'h0000, 32'h0000_1889, 8'd8},  // R8 id chunks
        '{1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0101, 32'h0000_0018, 8'd7},  // R7 low 8 bits only
        '{1'b1, 2'd2, 2'd2, 2'd2, 2'd2, 16'h0000, 32'h0000_0089, 8'd7},  // R7 x32 device
        '{1'b0, 2'd1, 2'd1, 2'd1, 2'd2, 16'h0020, 32'h0059_0051, 8'd8},  // R8 2-byte chunks
        '{1'b0, 2'd2, 2'd0, 2'd0, 2'd1, 16'h0044, 32'h0000_5252, 8'd9},  // R9 narrower than bank
        '{1'b0, 2'd2, 2'd1, 2'd1, 2'd2, 16'h009C, 32'h0016_0016, 8'd3},  // R3 device size
        '{1'b0, 2'd2, 2'd1, 2'd1, 2'd2, 16'h00B4, 32'h003F_003F, 8'd3},  // R3 blocks per device
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd1, 16'h002F, 32'h0000_0100, 8'd3},  // R3 sector length
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h003F, 32'h0000_0001, 8'd3},  // R3 protection count
        '{1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 16'h0020, 32'h0000_0051, 8'd2},  // R2 x8 in x16, 1-byte bank
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0052, 32'h0000_0000, 8'd4}   // R4 last index, undefined
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        mode_id = 1'b0;
    logic [15:0] offset = '0;
    logic [1:0]  acc_lg = '0;
    logic [1:0]  bank_lg = '0;
    logic [1:0]  dev_lg = '0;
    logic [1:0]  max_lg = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fqr_responder u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .mode_id  (mode_id),
        .offset   (offset),
        .acc_lg   (acc_lg),
        .bank_lg  (bank_lg),
        .dev_lg   (dev_lg),
        .max_lg   (max_lg),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_once(input vec_t v);
        @(negedge clk);
        mode_id = v.mode; bank_lg = v.bank; dev_lg = v.dev; max_lg = v.maxw;
        acc_lg = v.acc; offset = v.off; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {31'd0, rsp_valid}, 32'd0);
        chk("R10 reset data", rsp_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle valid", {31'd0, rsp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            read_once(VECS[i]);
            chk($sformatf("R1 valid vec %0d", i), {31'd0, rsp_valid}, 32'd1);
            chk($sformatf("R%0d data vec %0d", VECS[i].req_no, i), rsp_data, VECS[i].exp);
        end

        // R1: valid drops and data holds while inputs move without a request
        @(negedge clk);
        offset = 16'h0011; mode_id = 1'b0; bank_lg = 2'd0; dev_lg = 2'd0; max_lg = 2'd0;
        chk("R1 valid falls", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R1 data holds", rsp_data, 32'h0000_0000);

        // R1: back-to-back requests produce back-to-back responses
        @(negedge clk);
        acc_lg = 2'd0; offset = 16'h0011; req = 1'b1;
        @(negedge clk);
        chk("R1 b2b first", rsp_data, 32'h0000_0052);
        offset = 16'h0012;
        @(negedge clk);
        req = 1'b0;
        chk("R1 b2b second", rsp_data, 32'h0000_0059);
        chk("R1 b2b valid", {31'd0, rsp_valid}, 32'd1);

        // R10: reset mid-run clears the response
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset data", rsp_data, 32'd0);
        chk("R10 mid reset valid", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual hung expected finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule